// File: doc/BRIEF.md
# Bipolar Line Decoder with Substitution Recovery

This block turns a two-rail bipolar line signal back into a serial NRZ bit stream. Each rising edge of the receive clock takes one line symbol from the two rails. A pulse on exactly one rail is a mark, and no pulse is a space. A mode input picks one of two decodings. In plain alternate-mark decoding, every mark gives a one. In high-density decoding, a mark that repeats the polarity of the previous mark (a violation) can stand for a run of four substituted zeros, and the block puts those zeros back.

The decoded bits pass through a short delay line, so a substitution found later can still clear bits that have not yet reached the output. A registered error flag reports alternate-mark violations and symbols with both rails high. The flag follows the line symbols, so it does not wait for the decoded bit stream.

Top module: `hdb3_rx_decoder`

## Requirements
- R1: While `rstN` is low at a rising edge, both outputs are 0 after that edge, whatever the rails carry. The polarity memory restarts as positive, so a positive mark as the first mark after reset counts as a violation.
- R2: The decoded bit for a symbol sampled at rising edge k appears on `nrzOut` after rising edge k+4.
- R3: A space decodes as 0 and a mark that is not a violation decodes as 1, in either mode.
- R4: A violation is a single-rail mark whose polarity (positive = `posIn`) equals that of the last single-rail mark. In high-density mode (`hdb3Mode` = 1), a violation at symbol t is a legal substitution when symbol t-4 was a mark and symbols t-2 and t-1 were spaces. A legal substitution decodes as 0 and forces the bits of symbols t-3, t-2 and t-1 to 0. The bit of symbol t-4 is kept. Pattern +,0,0,0,+ therefore yields 1,0,0,0,0.
- R5: The form with a balancing pulse at t-3 is also legal when t-4 is a mark. Pattern -,+,0,0,+ yields 1,0,0,0,0, because the pulse at t-3 is cleared.
- R6: In high-density mode, a violation whose window does not match the R4 condition decodes as 1, leaves the earlier bits unchanged and keeps `errOut` low.
- R7: In alternate-mark mode (`hdb3Mode` = 0), every violation decodes as 1, sets `errOut` and never clears earlier bits.
- R8: A symbol with both rails high decodes as 1 and sets `errOut` in either mode. A run of n such symbols gives n cycles of `errOut`. These symbols do not change the polarity memory.
- R9: `errOut` is high during the cycle after the rising edge that sampled the offending symbol, and low after a symbol with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; rails sampled on rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| hdb3Mode | input | 1 | 1 = high-density decoding, 0 = alternate-mark decoding |
| posIn | input | 1 | Positive-rail pulse |
| negIn | input | 1 | Negative-rail pulse |
| nrzOut | output | 1 | Decoded serial data, four clocks after the symbol |
| errOut | output | 1 | Line error flag, one clock after the symbol |

## Verification
In a single clock edge, a legal substitution clears three delay stages while the real bit older than the window moves on toward the output. The bench provokes this by placing a genuine one exactly four symbols before each legal violation, both with spaces (R4) and with a balancing pulse (R5) between them. The scoreboard then expects that one to survive and its three younger neighbours to read as zeros. A second overlap occurs when both-rail symbols produce errors while bits from an earlier substitution are still draining. The two expectation queues are checked on every cycle, so a leak from one path into the other is caught.

// File: rtl/hdb3_rx_pkg.sv
package hdb3_rx_pkg;

  // Strobes that the line classifier sends to the delay datapath for each symbol.
  typedef struct packed {
    logic bitVal;   // decoded value of the current symbol
    logic subZero;  // legal substitution: clear the younger window bits
    logic errSet;   // line error for this symbol
  } rx_strobe_t;

  localparam int unsigned DEFAULT_LOOKBACK = 4;

endpackage

// File: rtl/hdb3_rx_ctrl.sv
module hdb3_rx_ctrl
  import hdb3_rx_pkg::*;
#(
  parameter int unsigned LOOKBACK = DEFAULT_LOOKBACK
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hdb3Mode,
  input  logic       posIn,
  input  logic       negIn,
  output rx_strobe_t strb
);

  localparam int unsigned OLDEST = LOOKBACK - 1;

  logic                lastPol;    // 1 = last single-rail mark was positive
  logic [LOOKBACK-1:0] markHist;   // bit 0 = previous symbol, bit OLDEST = four back

  logic isMark, isSingle, isBoth, isViol, windowOk, isLegal;

  always_comb begin
    isMark   = posIn | negIn;
    isSingle = posIn ^ negIn;
    isBoth   = posIn & negIn;
    isViol   = isSingle && (posIn == lastPol);
    windowOk = markHist[OLDEST] && !markHist[0] && !markHist[1];
    isLegal  = hdb3Mode && isViol && windowOk;

    strb.bitVal  = isMark && !isLegal;
    strb.subZero = isLegal;
    strb.errSet  = isBoth || (!hdb3Mode && isViol);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastPol  <= 1'b1;
      markHist <= '0;
    end else begin
      markHist <= {markHist[LOOKBACK-2:0], isMark};
      if (isSingle) begin
        lastPol <= posIn;
      end
    end
  end

  // R7: alternate-mark mode never substitutes
  a_r7_ami_no_subst: assert property (@(posedge clk) disable iff (!rstN)
    !hdb3Mode |-> !strb.subZero);

  // R8: both rails high decode as a flagged one
  a_r8_both_rails_one: assert property (@(posedge clk) disable iff (!rstN)
    (posIn && negIn) |-> (strb.bitVal && strb.errSet && !strb.subZero));

  // R8: polarity memory untouched by a both-rail symbol
  a_r8_pol_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(posIn && negIn)) |-> $stable(lastPol));

endmodule

// File: rtl/hdb3_rx_datapath.sv
module hdb3_rx_datapath
  import hdb3_rx_pkg::*;
#(
  parameter int unsigned LOOKBACK = DEFAULT_LOOKBACK
) (
  input  logic       clk,
  input  logic       rstN,
  input  rx_strobe_t strb,
  output logic       nrzOut,
  output logic       errOut
);

  logic [LOOKBACK-1:0] pipe;  // pipe[0] = newest decoded bit

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipe   <= '0;
      nrzOut <= 1'b0;
      errOut <= 1'b0;
    end else begin
      pipe[0] <= strb.bitVal;
      for (int i = 1; i < LOOKBACK; i++) begin
        pipe[i] <= strb.subZero ? 1'b0 : pipe[i-1];
      end
      nrzOut <= pipe[LOOKBACK-1];
      errOut <= strb.errSet;
    end
  end

  // R1: reset clears both outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    !rstN |=> (!nrzOut && !errOut));

  // R4: substitution leaves the younger window bits at zero
  a_r4_window_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strb.subZero |=> (pipe[LOOKBACK-1:1] == '0));

endmodule

// File: rtl/hdb3_rx_decoder.sv
module hdb3_rx_decoder
  import hdb3_rx_pkg::*;
#(
  parameter int unsigned LOOKBACK = DEFAULT_LOOKBACK
) (
  input  logic clk,
  input  logic rstN,
  input  logic hdb3Mode,
  input  logic posIn,
  input  logic negIn,
  output logic nrzOut,
  output logic errOut
);

  rx_strobe_t strb;

  hdb3_rx_ctrl #(.LOOKBACK(LOOKBACK)) ctrl_i (
    .clk(clk), .rstN(rstN), .hdb3Mode(hdb3Mode),
    .posIn(posIn), .negIn(negIn), .strb(strb)
  );

  hdb3_rx_datapath #(.LOOKBACK(LOOKBACK)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .nrzOut(nrzOut), .errOut(errOut)
  );

  // R9: a both-rail symbol is flagged on the following cycle
  a_r9_err_follows_rails: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(posIn && negIn)) |-> errOut);

endmodule

// File: tb/hdb3_rx_decoder_tb_top.sv
module hdb3_rx_decoder_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hdb3Mode = 1'b0;
  logic posIn = 1'b0;
  logic negIn = 1'b0;
  logic nrzOut, errOut;

  always #5 clk = ~clk;

  hdb3_rx_decoder dut_i (
    .clk(clk), .rstN(rstN), .hdb3Mode(hdb3Mode),
    .posIn(posIn), .negIn(negIn), .nrzOut(nrzOut), .errOut(errOut)
  );

  typedef struct {
    logic  val;
    string tag;
  } item_t;

  item_t bitQ[$];
  item_t errQ[$];

  int checks = 0;
  int fails = 0;
  bit started = 0;
  bit finished = 0;

  // Reference model state, built from the requirements
  logic  lastPol = 1'b1;
  logic  mh[4] = '{default: 1'b0};   // mh[0] = previous symbol was a mark
  item_t pend[3];                    // pend[0] = previous symbol's bit
  int    symCount = 0;

  task automatic check(input logic act, input logic exp, input string what, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic sym(input logic p, input logic n, input logic md, input string tag);
    logic mk, both, single, viol, legal, bitv, errv;
    item_t it;
    @(negedge clk);
    posIn = p; negIn = n; hdb3Mode = md;
    mk = p | n; both = p & n; single = p ^ n;
    viol  = single && (p == lastPol);
    legal = md && viol && mh[3] && !mh[0] && !mh[1];
    bitv  = mk && !legal;
    errv  = both || (!md && viol);
    if (legal) begin
      for (int i = 0; i < 3; i++) begin
        pend[i].val = 1'b0;
        pend[i].tag = tag;
      end
    end
    it.val = errv; it.tag = tag;
    errQ.push_back(it);
    if (symCount >= 3) bitQ.push_back(pend[2]);
    pend[2] = pend[1];
    pend[1] = pend[0];
    pend[0].val = bitv; pend[0].tag = tag;
    mh[3] = mh[2]; mh[2] = mh[1]; mh[1] = mh[0]; mh[0] = mk;
    if (single) lastPol = p;
    symCount++;
    started = 1;
  endtask

  task automatic symP(input logic md, input string tag); sym(1'b1, 1'b0, md, tag); endtask
  task automatic symN(input logic md, input string tag); sym(1'b0, 1'b1, md, tag); endtask
  task automatic symZ(input logic md, input string tag); sym(1'b0, 1'b0, md, tag); endtask
  task automatic symB(input logic md, input string tag); sym(1'b1, 1'b1, md, tag); endtask

  // Monitor: errors one cycle after the symbol (R9), bits four edges later (R2)
  initial begin
    int cyc;
    item_t it;
    cyc = 0;
    wait (started);
    while (!finished) begin
      @(negedge clk);
      cyc++;
      if (cyc >= 1 && errQ.size() > 0) begin
        it = errQ.pop_front();
        check(errOut, it.val, "errOut (R9 timing)", it.tag);
      end
      if (cyc >= 5 && bitQ.size() > 0) begin
        it = bitQ.pop_front();
        check(nrzOut, it.val, "nrzOut (R2 latency)", it.tag);
      end
    end
  end

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      pend[i].val = 1'b0;
      pend[i].tag = "R1";
    end
    // R1: reset with noisy rails keeps outputs low
    posIn = 1'b1; negIn = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(nrzOut, 1'b0, "nrzOut in reset", "R1");
      check(errOut, 1'b0, "errOut in reset", "R1");
    end
    posIn = 1'b0; negIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // Alternate-mark mode
    symP(1'b0, "R1");               // first positive mark is a violation
    symN(1'b0, "R3"); symP(1'b0, "R3"); symN(1'b0, "R3");
    symZ(1'b0, "R3"); symZ(1'b0, "R3");
    symN(1'b0, "R7");               // repeats negative: error, decoded one
    symZ(1'b0, "R7"); symZ(1'b0, "R7"); symZ(1'b0, "R7");
    symN(1'b0, "R7");               // substitution-like window, still no clearing
    symB(1'b0, "R8");
    symP(1'b0, "R3");
    symB(1'b0, "R8"); symB(1'b0, "R8"); symB(1'b0, "R8");
    symP(1'b0, "R8");               // polarity kept through both-rail run

    // High-density mode, last polarity positive
    symN(1'b1, "R2"); symZ(1'b1, "R2"); symP(1'b1, "R2"); symN(1'b1, "R2");
    symZ(1'b1, "R4"); symZ(1'b1, "R4"); symZ(1'b1, "R4");
    symN(1'b1, "R4");               // mark, 0, 0, 0, V
    symP(1'b1, "R5"); symN(1'b1, "R5");
    symZ(1'b1, "R5"); symZ(1'b1, "R5");
    symN(1'b1, "R5");               // mark, B, 0, 0, V
    symP(1'b1, "R6"); symZ(1'b1, "R6");
    symP(1'b1, "R6");               // violation too soon
    symZ(1'b1, "R6"); symZ(1'b1, "R6");
    symN(1'b1, "R6"); symZ(1'b1, "R6"); symZ(1'b1, "R6");
    symN(1'b1, "R6");               // space four back: not legal
    symB(1'b1, "R8");
    symP(1'b1, "R3"); symZ(1'b1, "R3");
    for (int i = 0; i < 8; i++) symZ(1'b1, "R2");

    repeat (3) @(negedge clk);
    finished = 1;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule